// File: doc/BRIEF.md
# Background Channel Accuracy Monitor

This block runs a continuous self-test over the output channels of a two- or four-channel angle simulator. It visits the channels one after another and spends a fixed dwell window on each. On the last cycle of a window it compares the channel's measured output angle with the commanded angle that was latched when the window opened. If the angle error is larger than a tolerance, it sets a sticky fail flag for that channel. A window is skipped without flagging in two cases: the channel is not driving, or it has no excitation. A window is also discarded if the commanded angle itself moved by more than the tolerance while the window was open.

Reporting runs only while a host enable bit is set. While it is enabled, the monitor also writes a fixed heartbeat pattern into an 8-bit verify register at a fixed period. The host can overwrite that register at any time, for example with zero. A later read then shows whether the background test is still alive. An interrupt request is raised while any fail flag is set and the interrupt enable is on. Angles are 16-bit binary fractions of a turn, so the default tolerance of 9 LSB is just under 0.05 degrees.

Top module: `chan_accuracy_monitor`

## Requirements
- R1: During and after reset, all fail flags are 0, the verify register is 0x00 and the interrupt request is 0.
- R2: Once the reporting enable rises, window k (k = 0, 1, 2, ...) judges channel k mod NCH. Each window lasts DWELL_TICKS clock cycles. If the enable is set before clock edge N+1, the result of window k is visible after edge N+(k+1)*DWELL_TICKS.
- R3: A channel is flagged when the wrap-around absolute difference (measured minus latched commanded, modulo 2^16) exceeds TOL_LSB. A difference equal to TOL_LSB is not flagged. The difference wraps through zero, so 0xFFFC against 0x0006 counts as 10 LSB.
- R4: The flag is set exactly at the clock edge that ends the channel's window, and not one cycle earlier.
- R5: If the current commanded angle differs from the value latched at window start by more than TOL_LSB on the window's last cycle, the window sets no flag. A move of exactly TOL_LSB does not suppress the flag.
- R6: A channel whose outputs-on bit or excitation-present bit is 0 on the window's last cycle is not flagged, whatever its angles.
- R7: While the reporting enable is 0, no fail flag is set and the channel sequence returns to channel 0.
- R8: Fail flags stay set until the host pulses the matching bit of the write-one-to-clear strobe. A strobe bit for a flag that is not set has no effect on the other flags.
- R9: If a clear strobe and a new fail for the same channel land on the same clock edge, the flag ends up set.
- R10: The interrupt request is 1 exactly while the interrupt enable is 1 and at least one fail flag is set.
- R11: While reporting is enabled, the verify register is loaded with 0x55 every HB_TICKS cycles. The first load comes HB_TICKS edges after the enable rises. A host write loads the written byte on the next edge. If a host write and a periodic load land on the same edge, 0x55 wins.
- R12: While reporting is disabled, the verify register changes only through host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_en | input | 1 | Enables background reporting and the heartbeat |
| irq_en | input | 1 | Enables the interrupt request |
| cmd_ang | input | NCH*ANG_W | Commanded angles, channel i in bits [i*ANG_W +: ANG_W] |
| meas_ang | input | NCH*ANG_W | Measured output angles, same packing |
| out_on | input | NCH | Channel output drivers are on |
| exc_ok | input | NCH | Channel excitation is present |
| flag_clr | input | NCH | Write-one-to-clear strobe for the fail flags |
| vfy_wr | input | 1 | Host write strobe for the verify register |
| vfy_wdata | input | 8 | Host write data for the verify register |
| fail_flags | output | NCH | Sticky per-channel accuracy fail flags |
| irq | output | 1 | Interrupt request |
| vfy_reg | output | 8 | Verify register |

## Verification
Two pairs of functions can act on the same state in one cycle. The first pair is a host clear strobe and the end of a failing window for the same channel. The bench raises the clear bit for exactly the cycle whose edge closes the failing window of that channel, and requires the flag to read set afterwards. The second pair is a host write of zero to the verify register and a heartbeat load. The bench times the write to land on a heartbeat edge and requires 0x55 afterwards. It also checks, one cycle away from a heartbeat edge, that a host write alone does take effect.

// File: rtl/cam_pkg.sv
package cam_pkg;

    // Pattern the monitor loads into the verify register as a heartbeat.
    localparam logic [7:0] HB_PATTERN = 8'h55;

    // Width of a binary angle: a full turn spans 2**ANGLE_BITS codes.
    localparam int ANGLE_BITS = 16;

    // 0.05 degree expressed in 16-bit binary angle codes (truncated).
    localparam int TOL_DEFAULT = 9;

endpackage

// File: rtl/cam_dwell_seq.sv
module cam_dwell_seq #(
    parameter  int NCH   = 4,
    parameter  int DWELL = 18_000_000,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic [CH_W-1:0] ch_o,
    output logic            win_start_o,
    output logic            win_last_o
);

    localparam int              CNT_W   = $clog2(DWELL + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DWELL - 1);
    localparam logic [CH_W-1:0]  CH_END  = CH_W'(NCH - 1);

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t state_q, state_d;

    always_comb begin
        state_d     = state_q;
        win_start_o = en && (state_q.cnt == '0);
        win_last_o  = en && (state_q.cnt == CNT_END);
        if (!en) begin
            state_d.cnt = '0;
            state_d.ch  = '0;
        end else if (win_last_o) begin
            state_d.cnt = '0;
            state_d.ch  = (state_q.ch == CH_END) ? '0 : state_q.ch + 1'b1;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ch_o = state_q.ch;

endmodule

// File: rtl/cam_window_judge.sv
module cam_window_judge #(
    parameter  int NCH   = 4,
    parameter  int ANG_W = 16,
    parameter  int TOL   = 9,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CH_W-1:0]    ch,
    input  logic               win_start,
    input  logic               win_last,
    input  logic [NCH*ANG_W-1:0] cmd_flat,
    input  logic [NCH*ANG_W-1:0] meas_flat,
    input  logic [NCH-1:0]     out_on,
    input  logic [NCH-1:0]     exc_ok,
    output logic [NCH-1:0]     hit_o
);

    localparam logic [ANG_W-1:0] TOL_V = ANG_W'(TOL);

    typedef struct packed {
        logic [ANG_W-1:0] base;
    } judge_state_t;

    judge_state_t state_q, state_d;

    logic [ANG_W-1:0] cmd_a  [NCH];
    logic [ANG_W-1:0] meas_a [NCH];
    logic [NCH-1:0]   qual;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign cmd_a[g]  = cmd_flat[g*ANG_W +: ANG_W];
        assign meas_a[g] = meas_flat[g*ANG_W +: ANG_W];
        assign qual[g]   = out_on[g] & exc_ok[g];
    end

    // Absolute distance between two angles taken the short way round.
    function automatic logic [ANG_W-1:0] wrap_dist(input logic [ANG_W-1:0] a,
                                                   input logic [ANG_W-1:0] b);
        logic [ANG_W-1:0] d;
        d = a - b;
        return d[ANG_W-1] ? (~d + 1'b1) : d;
    endfunction

    logic [ANG_W-1:0] cmd_sel, meas_sel;
    logic             qual_sel;
    logic             err_big, step_big, fire;

    always_comb begin
        cmd_sel  = cmd_a[ch];
        meas_sel = meas_a[ch];
        qual_sel = qual[ch];

        state_d      = state_q;
        if (win_start) begin
            state_d.base = cmd_sel;
        end

        err_big  = wrap_dist(meas_sel, state_q.base) > TOL_V;
        step_big = wrap_dist(cmd_sel, state_q.base) > TOL_V;
        fire     = win_last && qual_sel && err_big && !step_big;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_hit
        assign hit_o[g] = fire && (ch == CH_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/cam_heartbeat.sv
module cam_heartbeat #(
    parameter int         PERIOD = 10_000_000,
    parameter logic [7:0] PAT    = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] reg_o
);

    localparam int               CNT_W   = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       vreg;
    } hb_state_t;

    hb_state_t state_q, state_d;
    logic      tick;

    always_comb begin
        state_d = state_q;
        tick    = en && (state_q.cnt == CNT_END);

        if (!en || tick) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end

        // The periodic load wins over a host write on the same edge.
        if (tick) begin
            state_d.vreg = PAT;
        end else if (wr) begin
            state_d.vreg = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_o = state_q.vreg;

endmodule

// File: rtl/chan_accuracy_monitor.sv
module chan_accuracy_monitor #(
    parameter int NCH         = 4,
    parameter int ANG_W       = cam_pkg::ANGLE_BITS,
    parameter int TOL_LSB     = cam_pkg::TOL_DEFAULT,
    parameter int DWELL_TICKS = 18_000_000,
    parameter int HB_TICKS    = 10_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rpt_en,
    input  logic                 irq_en,
    input  logic [NCH*ANG_W-1:0] cmd_ang,
    input  logic [NCH*ANG_W-1:0] meas_ang,
    input  logic [NCH-1:0]       out_on,
    input  logic [NCH-1:0]       exc_ok,
    input  logic [NCH-1:0]       flag_clr,
    input  logic                 vfy_wr,
    input  logic [7:0]           vfy_wdata,
    output logic [NCH-1:0]       fail_flags,
    output logic                 irq,
    output logic [7:0]           vfy_reg
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CH_W-1:0] cur_ch;
    logic            win_start, win_last;
    logic [NCH-1:0]  hit;

    cam_dwell_seq #(
        .NCH   (NCH),
        .DWELL (DWELL_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (rpt_en),
        .ch_o        (cur_ch),
        .win_start_o (win_start),
        .win_last_o  (win_last)
    );

    cam_window_judge #(
        .NCH   (NCH),
        .ANG_W (ANG_W),
        .TOL   (TOL_LSB)
    ) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch        (cur_ch),
        .win_start (win_start),
        .win_last  (win_last),
        .cmd_flat  (cmd_ang),
        .meas_flat (meas_ang),
        .out_on    (out_on),
        .exc_ok    (exc_ok),
        .hit_o     (hit)
    );

    cam_heartbeat #(
        .PERIOD (HB_TICKS),
        .PAT    (cam_pkg::HB_PATTERN)
    ) u_hb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rpt_en),
        .wr    (vfy_wr),
        .wdata (vfy_wdata),
        .reg_o (vfy_reg)
    );

    typedef struct packed {
        logic [NCH-1:0] flags;
    } flag_state_t;

    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        // A new fail wins over a clear strobe on the same edge.
        state_d.flags = (state_q.flags & ~flag_clr) | (rpt_en ? hit : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fail_flags = state_q.flags;
    assign irq        = irq_en && (|state_q.flags);

endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rpt_en,
    input logic           irq_en,
    input logic [NCH-1:0] out_on,
    input logic [NCH-1:0] exc_ok,
    input logic [NCH-1:0] flag_clr,
    input logic           vfy_wr,
    input logic [NCH-1:0] fail_flags,
    input logic           irq,
    input logic [7:0]     vfy_reg
);

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (fail_flags == '0 && vfy_reg == 8'h00 && !irq)); // R1

    AST_ONE_CHANNEL_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $onehot0(fail_flags & ~$past(fail_flags))); // R2

    AST_ONLY_QUALIFIED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fail_flags & ~$past(fail_flags) & ~$past(out_on & exc_ok)) == '0)); // R6

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_en |=> ((fail_flags & ~$past(fail_flags)) == '0)); // R7

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(fail_flags) & ~$past(flag_clr) & ~fail_flags) == '0)); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && fail_flags != '0)); // R10

    AST_VERIFY_ONLY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        !vfy_wr |=> ($stable(vfy_reg) || vfy_reg == 8'h55)); // R11

    AST_VERIFY_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!rpt_en && !vfy_wr) |=> $stable(vfy_reg)); // R12

endmodule

bind chan_accuracy_monitor cam_checker #(.NCH(NCH)) u_cam_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rpt_en     (rpt_en),
    .irq_en     (irq_en),
    .out_on     (out_on),
    .exc_ok     (exc_ok),
    .flag_clr   (flag_clr),
    .vfy_wr     (vfy_wr),
    .fail_flags (fail_flags),
    .irq        (irq),
    .vfy_reg    (vfy_reg)
);

// File: tb/sim_chan_accuracy_monitor.sv
module sim_chan_accuracy_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int AW    = 16;
    localparam int DW    = 20;
    localparam int HB    = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rpt_en = 1'b0;
    logic              irq_en = 1'b0;
    logic [NCH*AW-1:0] cmd_ang = '0;
    logic [NCH*AW-1:0] meas_ang = '0;
    logic [NCH-1:0]    out_on = '1;
    logic [NCH-1:0]    exc_ok = '1;
    logic [NCH-1:0]    flag_clr = '0;
    logic              vfy_wr = 1'b0;
    logic [7:0]        vfy_wdata = '0;
    logic [NCH-1:0]    fail_flags;
    logic              irq;
    logic [7:0]        vfy_reg;

    chan_accuracy_monitor #(
        .NCH (NCH), .ANG_W (AW), .TOL_LSB (9),
        .DWELL_TICKS (DW), .HB_TICKS (HB)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .rpt_en (rpt_en), .irq_en (irq_en),
        .cmd_ang (cmd_ang), .meas_ang (meas_ang), .out_on (out_on),
        .exc_ok (exc_ok), .flag_clr (flag_clr), .vfy_wr (vfy_wr),
        .vfy_wdata (vfy_wdata), .fail_flags (fail_flags), .irq (irq),
        .vfy_reg (vfy_reg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int         at;
        int         kind;   // 0 flags, 1 verify register, 2 irq
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sb[$];

    task automatic expect_at(input int at, input int kind, input logic [7:0] val,
                             input string tag);
        exp_t it;
        int pos;
        it.at = at; it.kind = kind; it.val = val; it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > at) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, it);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic set_ch(input int ch, input logic [15:0] c, input logic [15:0] m);
        cmd_ang[ch*AW +: AW]  = c;
        meas_ang[ch*AW +: AW] = m;
    endtask

    // Monitor: pops the expectations due in this cycle and compares them.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = 8'(fail_flags);
                1:       act = vfy_reg;
                default: act = 8'(irq);
            endcase
            total++;
            if (it.at != cyc || act !== it.val) begin
                bad++;
                $display("FAIL %s cyc=%0d kind=%0d actual=%h expected=%h",
                         it.tag, cyc, it.kind, act, it.val);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            if (sb.size() != 0) begin
                total++; bad++;
                $display("FAIL scoreboard %0d expectations left actual=%0d expected=0",
                         sb.size(), sb.size());
            end
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        sb.delete();
        finish_run();
    end

    initial begin
        // R1: reset state
        expect_at(2, 0, 8'h0, "R1 flags in reset");
        expect_at(5, 0, 8'h0, "R1 flags after reset");
        expect_at(5, 1, 8'h0, "R1 verify after reset");
        expect_at(5, 2, 8'h0, "R1 irq after reset");

        // Scenario 1: enable at negedge 10 (N=10)
        expect_at(30, 0, 8'h0,  "R3 error equal to tolerance not flagged");
        expect_at(49, 0, 8'h0,  "R4 no flag before window end");
        expect_at(49, 2, 8'h0,  "R10 irq low without flags");
        expect_at(50, 0, 8'h2,  "R3 R2 wrapped error flags channel 1");
        expect_at(50, 2, 8'h1,  "R10 irq with flag and enable");
        expect_at(70, 0, 8'h6,  "R3 large error flags channel 2");
        expect_at(90, 0, 8'h6,  "R6 no excitation skips channel 3");
        expect_at(16, 1, 8'h00, "R11 no heartbeat before period");
        expect_at(17, 1, 8'h55, "R11 first heartbeat");
        expect_at(20, 1, 8'h00, "R11 host write takes effect");
        expect_at(24, 1, 8'h55, "R11 heartbeat restores pattern");
        expect_at(31, 1, 8'h55, "R11 heartbeat wins over host write");
        expect_at(96, 2, 8'h0,  "R10 irq masked by enable");
        expect_at(98, 0, 8'h2,  "R8 clear drops only strobed flag");
        expect_at(103, 1, 8'h00, "R12 host write while disabled");
        expect_at(140, 1, 8'h00, "R12 no heartbeat while disabled");
        expect_at(160, 0, 8'h2,  "R7 no flag set while disabled");
        expect_at(166, 0, 8'h0,  "R8 flag cleared by strobe");

        // Scenario 2: enable at negedge 200 (N=200)
        expect_at(206, 1, 8'h00, "R11 no heartbeat before period after re-enable");
        expect_at(207, 1, 8'h55, "R11 heartbeat after re-enable");
        expect_at(220, 0, 8'h0,  "R5 moved command suppresses flag");
        expect_at(240, 0, 8'h0,  "R6 output off skips channel 1");
        expect_at(260, 0, 8'h4,  "R9 R5 set beats clear, step of tolerance kept");
        expect_at(261, 2, 8'h1,  "R10 irq follows new flag");
        expect_at(280, 0, 8'h4,  "R2 channel 3 clean");

        wait_cyc(3);
        rst_n = 1'b1;

        // Scenario 1 stimulus
        set_ch(0, 16'h1000, 16'h1009);
        set_ch(1, 16'hFFFC, 16'h0006);
        set_ch(2, 16'h2000, 16'h1FF0);
        set_ch(3, 16'h3000, 16'h3064);
        exc_ok = 4'b0111;
        irq_en = 1'b1;
        wait_cyc(10);
        rpt_en = 1'b1;
        wait_cyc(19);
        vfy_wr = 1'b1; vfy_wdata = 8'h00;
        wait_cyc(20);
        vfy_wr = 1'b0;
        wait_cyc(30);
        vfy_wr = 1'b1;
        wait_cyc(31);
        vfy_wr = 1'b0;
        wait_cyc(95);
        irq_en = 1'b0;
        wait_cyc(97);
        flag_clr = 4'b0100;
        wait_cyc(98);
        flag_clr = '0;
        wait_cyc(100);
        rpt_en = 1'b0;
        wait_cyc(102);
        vfy_wr = 1'b1;
        wait_cyc(103);
        vfy_wr = 1'b0;
        wait_cyc(104);
        set_ch(0, 16'h1000, 16'h1032);
        wait_cyc(165);
        flag_clr = 4'b0010;
        wait_cyc(166);
        flag_clr = '0;

        // Scenario 2 stimulus
        wait_cyc(180);
        set_ch(0, 16'h4000, 16'h4040);
        set_ch(1, 16'h0100, 16'h0800);
        set_ch(2, 16'h5000, 16'h5020);
        set_ch(3, 16'h6000, 16'h6003);
        out_on = 4'b1101;
        exc_ok = 4'b1111;
        irq_en = 1'b1;
        wait_cyc(200);
        rpt_en = 1'b1;
        wait_cyc(205);
        cmd_ang[0*AW +: AW] = 16'h4040;
        wait_cyc(245);
        cmd_ang[2*AW +: AW] = 16'h5009;
        wait_cyc(259);
        flag_clr = 4'b0100;
        wait_cyc(260);
        flag_clr = '0;
        wait_cyc(300);
        finish_run();
    end

endmodule